// File: doc/BRIEF.md
# TDM Codec Control-Frame Register Port

This block is the codec side of a four-wire time-division serial link made of a serial clock, a frame strobe, a data input and a data output. Every frame carries one 16-bit word, most significant bit first. After reset the port is in programming mode. In that mode each word is decoded as a control word that reads or writes one of six 8-bit configuration registers. Read results are shifted back to the host on the data output during the following frame.

Setting a mode bit in register 1 moves the port into streaming mode. In streaming mode every received word is handed on, unchanged, to the converter path. A streamed word whose least significant bit is 1 asks the port to return to programming mode. Writes and mode changes never take effect at the moment a word arrives. They are applied at the next frame strobe, so the configuration stays constant for the whole of a frame.

The streaming output is a one-cycle `data_valid` strobe with `data_word` and has no ready input. The serial link cannot pause, so there is no back-pressure. The consumer must take the word in the cycle it is flagged, and the word stays on `data_word` until the next streamed word replaces it.

Top module: `tdm_ctl_port`

## Requirements
- R1: After reset, `prog_mode` is 1, every configuration byte on `cfg` is 0x00, and `dout` and `data_valid` are 0.
- R2: All port state is updated on the falling edge of `sclk`. `fs` is high for exactly one falling edge, and the word's bit 15 is sampled on the next falling edge. In a control word, bits 15:13 give the register number (1 to 6), bit 12 = 0 means a write, and bits 7:0 carry the data. A legal write stores that byte in the register. Register k appears on `cfg[8k-1 : 8k-8]`.
- R3: A write changes `cfg` only at the first `fs` falling edge after the word's last bit. Between that last bit and the next `fs`, `cfg` keeps its old value.
- R4: A legal read (bit 12 = 1, bit 11 = 0) captures the addressed register, with any write from the previous frame already applied. During the next frame, `dout` carries the 16-bit word 0x00 followed by that byte, MSB first, with each bit valid from one falling edge until the next. When no read is pending, `dout` is 0 for the whole frame.
- R5: A control word with bits 10:8 not equal to 111, or with register number 0 or 7, changes no register and produces no read data.
- R6: Bit 11 marks a broadcast. A broadcast write is stored like a normal write. A broadcast read returns an all-zero word.
- R7: When register 1 bit 6 becomes 1 at an `fs`, `prog_mode` drops to 0 at that same edge. From then on, words are not decoded as control words.
- R8: In streaming mode each complete word appears on `data_word`, and `data_valid` is high for exactly one cycle, starting at the falling edge that samples bit 0.
- R9: A streamed word with bit 0 = 1 has two effects at the next `fs`: register 1 bit 6 is cleared and `prog_mode` returns to 1. The word itself is still delivered on `data_word`.
- R10: An `fs` that arrives before all 16 bits of a word have been sampled discards the partial word, and a new word starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs | input | 1 | Frame strobe, one bit period wide, just before bit 15 |
| din | input | 1 | Serial data from the host, MSB first |
| dout | output | 1 | Serial read-back data to the host, MSB first |
| cfg | output | 48 | Six applied configuration bytes; register k in bits 8k-1 to 8k-8 |
| prog_mode | output | 1 | 1 in programming mode, 0 in streaming mode |
| data_word | output | 16 | Last word received in streaming mode |
| data_valid | output | 1 | One-cycle strobe marking a new `data_word` |

## Verification
Each word completes on the sixteenth falling edge after its strobe. `data_valid` is therefore checked one rising edge later, in the middle of the idle bit that follows. A write or mode request is checked twice: it must not be visible at that point, and it must be visible after the next frame's 17 bit periods. Read-back bits are sampled on each rising edge of the following frame, half a period after the falling edge that shifted them out. All inputs are driven on rising edges, so no sample falls on an edge where the design updates.

// File: rtl/tdm_ctl_pkg.sv
`timescale 1ns/1ps
package tdm_ctl_pkg;
  localparam int WORD_W   = 16;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 6;
  localparam int MODE_REG = 1;
  localparam int MODE_BIT = 6;

  typedef enum logic {
    MODE_PROG = 1'b0,
    MODE_DATA = 1'b1
  } port_mode_e;
endpackage

// File: rtl/tdm_rx_shifter.sv
`timescale 1ns/1ps
module tdm_rx_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_i,
  input  logic              din_i,
  output logic              shift_o,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [WORD_W-2:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              active_q;

  assign shift_o = active_q & ~fs_i;
  assign done_o  = shift_o && (cnt_q == LAST_BIT);
  assign word_o  = {sr_q, din_i};

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (fs_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (shift_o) begin
      sr_q  <= {sr_q[WORD_W-3:0], din_i};
      cnt_q <= cnt_q + 1'b1;
      if (done_o) active_q <= 1'b0;
    end
  end

  // R10: a strobe always restarts bit counting, even mid-word
  p_restart_r10: assert property (@(negedge clk) disable iff (!rst_n)
    fs_i |=> (active_q && cnt_q == '0));
endmodule

// File: rtl/tdm_frame_decoder.sv
`timescale 1ns/1ps
module tdm_frame_decoder #(
  parameter int WORD_W   = 16,
  parameter int REG_W    = 8,
  parameter int NUM_REGS = 6,
  parameter int ADDR_W   = 3,
  parameter bit FMT_15P1 = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fs_i,
  input  logic                      done_i,
  input  logic [WORD_W-1:0]         word_i,
  input  logic                      data_mode_i,
  input  logic [NUM_REGS*REG_W-1:0] regs_i,
  output logic                      wr_pend_o,
  output logic [ADDR_W-1:0]         wr_addr_o,
  output logic [REG_W-1:0]          wr_data_o,
  output logic                      rd_pend_o,
  output logic [REG_W-1:0]          rd_byte_o,
  output logic                      exit_pend_o,
  output logic                      dvalid_o,
  output logic [WORD_W-1:0]         dword_o
);
  localparam int RD_BIT = WORD_W - ADDR_W - 1;
  localparam int BC_BIT = RD_BIT - 1;
  localparam int MARK_W = BC_BIT - REG_W;

  logic [ADDR_W-1:0] addr;
  logic              is_rd, is_bc, addr_ok, legal, exit_bit;
  logic [MARK_W-1:0] mark;
  logic [REG_W-1:0]  rd_sel;

  assign addr    = word_i[WORD_W-1 -: ADDR_W];
  assign is_rd   = word_i[RD_BIT];
  assign is_bc   = word_i[BC_BIT];
  assign mark    = word_i[REG_W +: MARK_W];
  assign addr_ok = (addr != '0) && (addr <= ADDR_W'(NUM_REGS));
  assign legal   = (&mark) && addr_ok;

  generate
    if (FMT_15P1) begin : g_flag_exit
      assign exit_bit = word_i[0];
    end else begin : g_no_exit
      assign exit_bit = 1'b0;
    end
  endgenerate

  always_comb begin
    rd_sel = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (addr == ADDR_W'(k + 1)) rd_sel = regs_i[k*REG_W +: REG_W];
    end
  end

  logic                wr_q, rd_q, exit_q, dv_q;
  logic [ADDR_W-1:0]   wa_q;
  logic [REG_W-1:0]    wd_q, rb_q;
  logic [WORD_W-1:0]   dw_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      exit_q <= 1'b0;
      dv_q   <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
      rb_q   <= '0;
      dw_q   <= '0;
    end else begin
      dv_q <= done_i & data_mode_i;
      if (fs_i) begin
        wr_q   <= 1'b0;
        rd_q   <= 1'b0;
        exit_q <= 1'b0;
      end else if (done_i) begin
        if (data_mode_i) begin
          dw_q   <= word_i;
          exit_q <= exit_bit;
        end else if (legal) begin
          if (is_rd) begin
            if (!is_bc) begin
              rd_q <= 1'b1;
              rb_q <= rd_sel;
            end
          end else begin
            wr_q <= 1'b1;
            wa_q <= addr;
            wd_q <= word_i[REG_W-1:0];
          end
        end
      end
    end
  end

  assign wr_pend_o   = wr_q;
  assign wr_addr_o   = wa_q;
  assign wr_data_o   = wd_q;
  assign rd_pend_o   = rd_q;
  assign rd_byte_o   = rb_q;
  assign exit_pend_o = exit_q;
  assign dvalid_o    = dv_q;
  assign dword_o     = dw_q;

  // R7: no control write can be pending while streaming
  p_no_ctl_in_data_r7: assert property (@(negedge clk) disable iff (!rst_n)
    data_mode_i |-> !wr_q);
  // R8: the word strobe lasts a single cycle
  p_valid_pulse_r8: assert property (@(negedge clk) disable iff (!rst_n)
    dv_q |=> !dv_q);
endmodule

// File: rtl/tdm_reg_bank.sv
`timescale 1ns/1ps
module tdm_reg_bank #(
  parameter int REG_W    = 8,
  parameter int NUM_REGS = 6,
  parameter int ADDR_W   = 3,
  parameter int MODE_REG = 1,
  parameter int MODE_BIT = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      apply_i,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [REG_W-1:0]          wr_data_i,
  input  logic                      exit_i,
  output logic [NUM_REGS*REG_W-1:0] regs_o,
  output logic                      mode_next_o
);
  localparam int MODE_POS = (MODE_REG - 1) * REG_W + MODE_BIT;

  logic [NUM_REGS*REG_W-1:0] next_flat;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [REG_W-1:0] q, d;
      always_comb begin
        d = q;
        if (wr_i && wr_addr_i == ADDR_W'(g + 1)) d = wr_data_i;
        if ((g == MODE_REG - 1) && exit_i) d[MODE_BIT] = 1'b0;
      end
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (apply_i) q <= d;
      end
      assign regs_o[g*REG_W +: REG_W]    = q;
      assign next_flat[g*REG_W +: REG_W] = d;
    end
  endgenerate

  assign mode_next_o = next_flat[MODE_POS];

  // R3: configuration is frozen except at a frame strobe
  p_cfg_hold_r3: assert property (@(negedge clk) disable iff (!rst_n)
    !apply_i |=> $stable(regs_o));
endmodule

// File: rtl/tdm_tx_shifter.sv
`timescale 1ns/1ps
module tdm_tx_shifter #(
  parameter int WORD_W = 16,
  parameter int REG_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_i,
  input  logic             shift_i,
  input  logic             rd_pend_i,
  input  logic [REG_W-1:0] rd_byte_i,
  output logic             dout_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (fs_i)    sr_q <= rd_pend_i ? {{(WORD_W-REG_W){1'b0}}, rd_byte_i} : '0;
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], 1'b0};
  end

  assign dout_o = sr_q[WORD_W-1];

  // R4: the upper byte of every returned word is zero
  p_read_high_zero_r4: assert property (@(negedge clk) disable iff (!rst_n)
    fs_i |=> (sr_q[WORD_W-1:REG_W] == '0));
endmodule

// File: rtl/tdm_ctl_port.sv
`timescale 1ns/1ps
module tdm_ctl_port
  import tdm_ctl_pkg::*;
#(
  parameter int WORD_W_P   = WORD_W,
  parameter int REG_W_P    = REG_W,
  parameter int NUM_REGS_P = NUM_REGS,
  parameter int MODE_REG_P = MODE_REG,
  parameter int MODE_BIT_P = MODE_BIT,
  parameter bit FMT_15P1   = 1'b1
) (
  input  logic                          sclk,
  input  logic                          rst_n,
  input  logic                          fs,
  input  logic                          din,
  output logic                          dout,
  output logic [NUM_REGS_P*REG_W_P-1:0] cfg,
  output logic                          prog_mode,
  output logic [WORD_W_P-1:0]           data_word,
  output logic                          data_valid
);
  localparam int ADDR_W = $clog2(NUM_REGS_P + 1);

  logic                shift, done;
  logic [WORD_W_P-1:0] word;
  logic                wr_pend, rd_pend, exit_pend, mode_next;
  logic [ADDR_W-1:0]   wr_addr;
  logic [REG_W_P-1:0]  wr_data, rd_byte;
  port_mode_e          mode_q;

  tdm_rx_shifter #(.WORD_W(WORD_W_P)) u_rx (
    .clk(sclk), .rst_n(rst_n), .fs_i(fs), .din_i(din),
    .shift_o(shift), .done_o(done), .word_o(word)
  );

  tdm_frame_decoder #(
    .WORD_W(WORD_W_P), .REG_W(REG_W_P), .NUM_REGS(NUM_REGS_P),
    .ADDR_W(ADDR_W), .FMT_15P1(FMT_15P1)
  ) u_dec (
    .clk(sclk), .rst_n(rst_n), .fs_i(fs), .done_i(done), .word_i(word),
    .data_mode_i(mode_q == MODE_DATA), .regs_i(cfg),
    .wr_pend_o(wr_pend), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_pend_o(rd_pend), .rd_byte_o(rd_byte), .exit_pend_o(exit_pend),
    .dvalid_o(data_valid), .dword_o(data_word)
  );

  tdm_reg_bank #(
    .REG_W(REG_W_P), .NUM_REGS(NUM_REGS_P), .ADDR_W(ADDR_W),
    .MODE_REG(MODE_REG_P), .MODE_BIT(MODE_BIT_P)
  ) u_bank (
    .clk(sclk), .rst_n(rst_n), .apply_i(fs), .wr_i(wr_pend),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .exit_i(exit_pend),
    .regs_o(cfg), .mode_next_o(mode_next)
  );

  tdm_tx_shifter #(.WORD_W(WORD_W_P), .REG_W(REG_W_P)) u_tx (
    .clk(sclk), .rst_n(rst_n), .fs_i(fs), .shift_i(shift),
    .rd_pend_i(rd_pend), .rd_byte_i(rd_byte), .dout_o(dout)
  );

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n)  mode_q <= MODE_PROG;
    else if (fs) mode_q <= mode_next ? MODE_DATA : MODE_PROG;
  end

  assign prog_mode = (mode_q == MODE_PROG);

  // R7: the mode register moves only on a frame strobe
  p_mode_at_strobe_r7: assert property (@(negedge sclk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(fs));
  // R9: an exit request always lands the port in programming mode
  p_exit_to_prog_r9: assert property (@(negedge sclk) disable iff (!rst_n)
    (fs && exit_pend) |=> prog_mode);
endmodule

// File: tb/tdm_ctl_port_bench.sv
`timescale 1ns/1ps
module tdm_ctl_port_bench;
  logic        sclk = 1'b0, rst_n = 1'b0, fs = 1'b0, din = 1'b0;
  logic        dout, prog_mode, data_valid;
  logic [47:0] cfg;
  logic [15:0] data_word;

  int errs = 0, checks = 0;
  bit finished = 0;

  always #2.5 sclk = ~sclk;

  tdm_ctl_port u_tdm_ctl_port (
    .sclk(sclk), .rst_n(rst_n), .fs(fs), .din(din), .dout(dout), .cfg(cfg),
    .prog_mode(prog_mode), .data_word(data_word), .data_valid(data_valid)
  );

  // requirement-level model
  logic [7:0] exp_reg [1:6];
  bit         exp_data, p_wr, p_rd, p_exit, exp_dv;
  int         p_a;
  logic [7:0] p_d, p_byte;
  logic [15:0] exp_out;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mkw(int a, bit rd, bit bc, int m, logic [7:0] d);
    return {a[2:0], rd, bc, m[2:0], d};
  endfunction

  task automatic boundary();
    if (p_wr) exp_reg[p_a] = p_d;
    if (p_exit) exp_reg[1][6] = 1'b0;
    exp_out  = p_rd ? {8'h00, p_byte} : 16'h0000;
    exp_data = exp_reg[1][6];
    p_wr = 0; p_rd = 0; p_exit = 0;
  endtask

  task automatic decode(logic [15:0] w);
    int a = int'(w[15:13]);
    exp_dv = exp_data;
    if (exp_data) p_exit = w[0];
    else if (w[10:8] == 3'b111 && a >= 1 && a <= 6) begin
      if (w[12]) begin
        if (!w[11]) begin p_rd = 1; p_byte = exp_reg[a]; end
      end else begin
        p_wr = 1; p_a = a; p_d = w[7:0];
      end
    end
  endtask

  task automatic check_state(string tag);
    for (int a = 1; a <= 6; a++)
      chk(cfg[(a-1)*8 +: 8] == exp_reg[a], tag, $sformatf("cfg reg%0d", a),
          cfg[(a-1)*8 +: 8], exp_reg[a]);
    chk(prog_mode == !exp_data, tag, "prog_mode", prog_mode, !exp_data);
  endtask

  task automatic frame(logic [15:0] w, string tag);
    logic [15:0] got;
    bit dv;
    logic [15:0] dw;
    boundary();
    @(posedge sclk); fs = 1'b1; din = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(posedge sclk);
      fs = 1'b0;
      got[15-i] = dout;
      din = w[15-i];
    end
    @(posedge sclk);
    din = 1'b0;
    dv = data_valid;
    dw = data_word;
    decode(w);
    chk(got == exp_out, "R4", "read-back word", got, exp_out);
    chk(dv == exp_dv, "R8", "data_valid", dv, exp_dv);
    if (exp_dv) chk(dw == w, "R8", "data_word", dw, w);
    check_state(tag);
  endtask

  task automatic partial(logic [15:0] w, int n, string tag);
    boundary();
    @(posedge sclk); fs = 1'b1; din = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge sclk);
      fs = 1'b0;
      din = w[15-i];
    end
    check_state(tag);
  endtask

  initial begin
    logic [7:0] v;
    for (int a = 1; a <= 6; a++) exp_reg[a] = 8'h00;
    exp_data = 0; p_wr = 0; p_rd = 0; p_exit = 0; exp_out = 0;
    p_a = 1; p_d = 0; p_byte = 0; exp_dv = 0;
    repeat (4) @(posedge sclk);
    rst_n = 1'b1;
    @(posedge sclk);
    // R1: reset state
    for (int a = 1; a <= 6; a++)
      chk(cfg[(a-1)*8 +: 8] == 8'h00, "R1", "reset cfg", cfg[(a-1)*8 +: 8], 0);
    chk(prog_mode == 1'b1, "R1", "reset prog_mode", prog_mode, 1);
    chk(dout == 1'b0, "R1", "reset dout", dout, 0);
    chk(data_valid == 1'b0, "R1", "reset data_valid", data_valid, 0);

    // R3 write sweep: each write lands one frame late
    for (int a = 1; a <= 6; a++) begin
      v = 8'((a * 41 + 3)) & 8'hBF;
      frame(mkw(a, 0, 0, 7, v), "R3");
    end
    // R2 read-back sweep
    for (int a = 1; a <= 6; a++) frame(mkw(a, 1, 0, 7, 8'h00), "R2");
    frame(16'h0000, "R2");
    // R3 write then immediate read of the same register
    for (int a = 1; a <= 6; a++) begin
      v = 8'(~(a * 41 + 3)) & 8'hBF;
      frame(mkw(a, 0, 0, 7, v), "R3");
      frame(mkw(a, 1, 0, 7, 8'h00), "R3");
    end
    frame(16'h0000, "R3");
    // R5 illegal markers and addresses
    for (int m = 0; m < 7; m++) frame(mkw(2, 0, 0, m, 8'hFF), "R5");
    frame(mkw(0, 0, 0, 7, 8'h77), "R5");
    frame(mkw(7, 0, 0, 7, 8'h77), "R5");
    frame(mkw(0, 1, 0, 7, 8'h00), "R5");
    frame(mkw(7, 1, 0, 7, 8'h00), "R5");
    frame(mkw(3, 1, 0, 5, 8'h00), "R5");
    frame(16'h0000, "R5");
    // R6 broadcast
    frame(mkw(3, 0, 1, 7, 8'h96), "R6");
    frame(mkw(3, 1, 1, 7, 8'h00), "R6");
    frame(mkw(3, 1, 0, 7, 8'h00), "R6");
    frame(16'h0000, "R6");
    // R10 aborted words
    partial(mkw(4, 0, 0, 7, 8'h5A), 9, "R10");
    frame(16'h0000, "R10");
    frame(mkw(4, 1, 0, 7, 8'h00), "R10");
    partial(mkw(5, 0, 0, 7, 8'hC3), 15, "R10");
    frame(mkw(4, 1, 0, 7, 8'h00), "R10");
    frame(16'h0000, "R10");
    // R7 / R8 / R9 mode round trips
    for (int r = 0; r < 2; r++) begin
      frame(mkw(1, 0, 0, 7, 8'h40 | 8'(r * 3)), "R7");
      for (int k = 0; k < 6; k++)
        frame(mkw(2, 0, 0, 7, 8'(8'h10 + k * 2)), "R7");
      frame(16'hFFFE, "R8");
      frame(16'h0000, "R8");
      frame(16'h1235 + 16'(r * 2), "R9");
      frame(mkw(5, 0, 0, 7, 8'h3C + 8'(r)), "R9");
      frame(mkw(5, 1, 0, 7, 8'h00), "R9");
      frame(16'h0000, "R9");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge sclk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule